// File: doc/BRIEF.md
# ATA Shadow Task-File with Register FIS Builder

This block is the host-side copy of the ATA task-file registers in a SATA host controller. Software writes byte-wide registers through a small register port. Five of them (features, sector count, sector number, cylinder low, cylinder high) keep two bytes each, so that 48-bit LBA commands can be loaded. The newest byte is the current entry, and the byte written before it is the previous entry. A read-select bit in the device-control register decides which of the two entries a read returns.

When software writes the command register, the block freezes the task file. It packs the task file into a five-dword host-to-device register FIS and sends the FIS on a valid/ready dword stream, dword 0 first. A write to the device-control register alone also sends a FIS, with the command flag (C bit) cleared.

The sequencer has two states. In IDLE, register writes are accepted. The transition IDLE to SEND is taken on an accepted write to the command register or to the device-control register. In SEND, a dword index steps from 0 to 4 on each accepted dword. The transition SEND to IDLE is taken when dword 4 is accepted.

Top module: `ata_taskfile_fis`

## Requirements
- R1: After reset, both entries of every two-entry register are 00h, device/head, command and device-control are 00h, and no FIS is offered.
- R2: The register address map is 0 features, 1 sector count, 2 sector number, 3 cylinder low, 4 cylinder high, 5 device/head, 6 command, 7 device-control. A write to a two-entry register (addresses 0 to 4) moves its current byte into the previous entry and stores the new byte as current.
- R3: When device-control bit 7 is 0, a read of addresses 0 to 4 returns the current entry. When bit 7 is 1, the read returns the previous entry.
- R4: Device/head, command and device-control hold a single byte each. Reads of these registers return that byte whatever the value of device-control bit 7.
- R5: An accepted write to the command register starts a FIS whose dword 0 is, from byte 0 to byte 3: 27h, 80h (C bit set), command, current features.
- R6: The remaining dwords are laid out as follows. Dword 1 holds current sector number, current cylinder low, current cylinder high and device/head in bytes 0 to 3. Dword 2 holds the previous entries of sector number, cylinder low, cylinder high and features in bytes 0 to 3. Dword 3 holds current sector count, previous sector count, 00h and device-control in bytes 0 to 3. Dword 4 is zero.
- R7: An accepted write to device-control alone starts a FIS whose byte 1 of dword 0 is 00h (C bit clear). The FIS carries the stored command byte.
- R8: A dword stays on the stream unchanged while valid is high and ready is low. The last flag is high only with dword 4. Exactly five dwords are sent per FIS.
- R9: Register writes of any address made while a FIS is being sent are ignored. They change neither the read values nor the FIS, and they start no further FIS.
- R10: Writes to the task-file registers may come in any order before the command write, and the FIS reflects the final contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (map in R2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| fis_valid | output | 1 | FIS dword valid |
| fis_ready | input | 1 | Downstream accepts the dword |
| fis_data | output | 32 | FIS dword |
| fis_last | output | 1 | Marks dword 4 |

## Verification
The FIS builder is driven with three kinds of stimulus. The first is a 48-bit load, in which every two-entry register is written twice in scrambled order. The second is a 28-bit load, in which each register is written once, so the previous entries carry older bytes or zero. The third is a control-only write. Together these separate the current and previous entries, the C bit, and the source of each byte lane. Each FIS is also sent against both a ready line held high and a ready line stalled irregularly, which checks that data is held and that the last flag falls on the right dword. Reads are made with device-control bit 7 both clear and set, and writes are made while a FIS is in flight, to show that those writes leave the task file unchanged.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
    localparam int TF_AW      = 3;
    localparam int TF_BW      = 8;
    localparam int TF_NPAIR   = 5;
    localparam int FIS_DWORDS = 5;
    localparam int FIS_IW     = $clog2(FIS_DWORDS);

    localparam logic [TF_AW-1:0] A_FEAT = 3'd0;
    localparam logic [TF_AW-1:0] A_SCNT = 3'd1;
    localparam logic [TF_AW-1:0] A_SNUM = 3'd2;
    localparam logic [TF_AW-1:0] A_CYLL = 3'd3;
    localparam logic [TF_AW-1:0] A_CYLH = 3'd4;
    localparam logic [TF_AW-1:0] A_DEVH = 3'd5;
    localparam logic [TF_AW-1:0] A_CMD  = 3'd6;
    localparam logic [TF_AW-1:0] A_CTRL = 3'd7;

    localparam logic [7:0] FIS_H2D_TYPE = 8'h27;

    typedef enum logic [0:0] {ST_IDLE, ST_SEND} fis_state_t;
endpackage

// File: rtl/tf_fifo2.sv
module tf_fifo2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '0;
            prev <= '0;
        end else if (push) begin
            prev <= cur;
            cur  <= din;
        end
    end

    AST_PUSH_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> prev == $past(cur)); // R2
endmodule

// File: rtl/tf_fis_pack.sv
module tf_fis_pack
    import ata_tf_pkg::*;
(
    input  logic [TF_NPAIR-1:0][TF_BW-1:0] cur,
    input  logic [TF_NPAIR-1:0][TF_BW-1:0] prev,
    input  logic [TF_BW-1:0]               devh,
    input  logic [TF_BW-1:0]               cmd,
    input  logic [TF_BW-1:0]               ctrl,
    input  logic                           cbit,
    input  logic [FIS_IW-1:0]              idx,
    output logic [31:0]                    dword
);
    always_comb begin
        unique case (idx)
            3'd0: dword = {cur[A_FEAT], cmd, cbit, 7'd0, FIS_H2D_TYPE};
            3'd1: dword = {devh, cur[A_CYLH], cur[A_CYLL], cur[A_SNUM]};
            3'd2: dword = {prev[A_FEAT], prev[A_CYLH], prev[A_CYLL], prev[A_SNUM]};
            3'd3: dword = {ctrl, 8'h00, prev[A_SCNT], cur[A_SCNT]};
            default: dword = 32'd0;
        endcase
    end
endmodule

// File: rtl/tf_fis_seq.sv
module tf_fis_seq
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ready,
    output logic              valid,
    output logic              last,
    output logic [FIS_IW-1:0] idx,
    output logic              busy
);
    localparam logic [FIS_IW-1:0] LAST_IDX = FIS_IW'(FIS_DWORDS - 1);

    fis_state_t        state, state_nx;
    logic [FIS_IW-1:0] idx_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        valid    = 1'b0;
        last     = 1'b0;
        busy     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idx_nx = '0;
                if (start) state_nx = ST_SEND;
            end
            ST_SEND: begin
                valid = 1'b1;
                busy  = 1'b1;
                last  = (idx == LAST_IDX);
                if (ready) begin
                    if (idx == LAST_IDX) begin
                        state_nx = ST_IDLE;
                        idx_nx   = '0;
                    end else begin
                        idx_nx = idx + 1'b1;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX); // R8
    AST_STALL_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(idx)); // R8
endmodule

// File: rtl/ata_taskfile_fis.sv
module ata_taskfile_fis
    import ata_tf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [TF_AW-1:0] reg_addr,
    input  logic [TF_BW-1:0] reg_wdata,
    output logic [TF_BW-1:0] reg_rdata,
    output logic             fis_valid,
    input  logic             fis_ready,
    output logic [31:0]      fis_data,
    output logic             fis_last
);
    logic [TF_NPAIR-1:0][TF_BW-1:0] pair_cur, pair_prev;
    logic [TF_BW-1:0]  devh_q, cmd_q, ctrl_q;
    logic              cbit_q;
    logic              busy, wr_ok, start;
    logic [FIS_IW-1:0] idx;

    assign wr_ok = reg_wr && !busy;
    assign start = wr_ok && (reg_addr == A_CMD || reg_addr == A_CTRL);

    for (genvar g = 0; g < TF_NPAIR; g++) begin : g_pair
        tf_fifo2 #(.W(TF_BW)) u_fifo (
            .clk (clk),
            .rst_n(rst_n),
            .push(wr_ok && reg_addr == TF_AW'(g)),
            .din (reg_wdata),
            .cur (pair_cur[g]),
            .prev(pair_prev[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devh_q <= '0;
            cmd_q  <= '0;
            ctrl_q <= '0;
            cbit_q <= 1'b0;
        end else if (wr_ok) begin
            if (reg_addr == A_DEVH) devh_q <= reg_wdata;
            if (reg_addr == A_CMD)  cmd_q  <= reg_wdata;
            if (reg_addr == A_CTRL) ctrl_q <= reg_wdata;
            if (start)              cbit_q <= (reg_addr == A_CMD);
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_DEVH: reg_rdata = devh_q;
            A_CMD:  reg_rdata = cmd_q;
            A_CTRL: reg_rdata = ctrl_q;
            default: reg_rdata = ctrl_q[7] ? pair_prev[reg_addr] : pair_cur[reg_addr];
        endcase
    end

    tf_fis_seq u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .ready(fis_ready),
        .valid(fis_valid),
        .last (fis_last),
        .idx  (idx),
        .busy (busy)
    );

    tf_fis_pack u_pack (
        .cur  (pair_cur),
        .prev (pair_prev),
        .devh (devh_q),
        .cmd  (cmd_q),
        .ctrl (ctrl_q),
        .cbit (cbit_q),
        .idx  (idx),
        .dword(fis_data)
    );

    AST_FIRST_IS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fis_valid) |-> fis_data[7:0] == FIS_H2D_TYPE); // R5
    AST_CMD_SETS_C: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !fis_valid && reg_addr == A_CMD |=> fis_valid && fis_data[15]); // R5
    AST_CTRL_CLEARS_C: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !fis_valid && reg_addr == A_CTRL |=> fis_valid && !fis_data[15]); // R7
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fis_valid && !fis_ready |=> fis_valid && $stable(fis_data)); // R8
    AST_LAST_IN_FIS: assert property (@(posedge clk) disable iff (!rst_n)
        fis_last |-> fis_valid); // R8
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        fis_valid |=> $stable(pair_cur) && $stable(pair_prev) && $stable(cmd_q)); // R9
endmodule

// File: tb/ata_taskfile_fis_bench.sv
module ata_taskfile_fis_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        fis_valid, fis_last;
    logic        fis_ready = 1'b1;
    logic [31:0] fis_data;

    int errors = 0;
    int checks = 0;
    int stall_mode = 0;
    int cyc = 0;
    logic [31:0] expq[$];
    int dw_seen = 0;

    logic [7:0] m_cur[5], m_prev[5];
    logic [7:0] m_devh, m_cmd, m_ctrl;

    always #4 clk = ~clk;

    ata_taskfile_fis u_ata_taskfile_fis (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fis_valid(fis_valid),
        .fis_ready(fis_ready), .fis_data(fis_data), .fis_last(fis_last)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        cyc++;
        fis_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    // Monitor: pops expected dwords as the design hands them over
    always @(negedge clk) begin
        if (rst_n && fis_valid && fis_ready) begin
            if (expq.size() == 0) begin
                check("R9 unexpected dword", fis_data, 32'hxxxxxxxx);
            end else begin
                check("R5/R6/R7 dword", fis_data, expq.pop_front());
                check("R8 last flag", {31'd0, fis_last}, {31'd0, dw_seen == 4});
                dw_seen = (dw_seen == 4) ? 0 : dw_seen + 1;
            end
        end
    end

    task automatic push_fis(bit cflag);
        expq.push_back({m_cur[0], m_cmd, cflag, 7'd0, 8'h27});
        expq.push_back({m_devh, m_cur[4], m_cur[3], m_cur[2]});
        expq.push_back({m_prev[0], m_prev[4], m_prev[3], m_prev[2]});
        expq.push_back({m_ctrl, 8'h00, m_prev[1], m_cur[1]});
        expq.push_back(32'd0);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d, bit model);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
        if (model) begin
            if (a < 3'd5) begin
                m_prev[a] = m_cur[a];
                m_cur[a]  = d;
            end else if (a == 3'd5) m_devh = d;
            else if (a == 3'd6) begin m_cmd = d; push_fis(1'b1); end
            else begin m_ctrl = d; push_fis(1'b0); end
        end
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        check(req, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!fis_valid && expq.size() == 0) break;
        end
        check("R8 all dwords sent", expq.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin m_cur[i] = 0; m_prev[i] = 0; end
        m_devh = 0; m_cmd = 0; m_ctrl = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 no FIS after reset", {31'd0, fis_valid}, 32'd0);
        for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset value");

        // R2 R10: 48-bit load in scrambled order
        wr(3'd4, 8'h44, 1); wr(3'd1, 8'h11, 1); wr(3'd0, 8'hF0, 1);
        wr(3'd3, 8'h33, 1); wr(3'd2, 8'h22, 1); wr(3'd5, 8'hE0, 1);
        wr(3'd2, 8'hA2, 1); wr(3'd0, 8'hA0, 1); wr(3'd4, 8'hA4, 1);
        wr(3'd1, 8'hA1, 1); wr(3'd3, 8'hA3, 1);
        rd(3'd0, 8'hA0, "R2 newest features");
        rd(3'd3, 8'hA3, "R2 newest cyl low");
        wr(3'd7, 8'h80, 1);            // control write with bit 7 set, C=0 FIS (R7)
        wait_done();
        rd(3'd0, 8'hF0, "R3 older features");
        rd(3'd1, 8'h11, "R3 older sector count");
        rd(3'd4, 8'h44, "R3 older cyl high");
        rd(3'd5, 8'hE0, "R4 device/head ignores bit 7");
        rd(3'd7, 8'h80, "R4 control readback");
        wr(3'd7, 8'h00, 1);
        wait_done();
        rd(3'd2, 8'hA2, "R3 bit 7 clear gives newest");

        // R5 R6: command under full ready, then stalled ready
        wr(3'd6, 8'h24, 1);
        wait_done();
        rd(3'd6, 8'h24, "R4 command readback");
        stall_mode = 1;
        wr(3'd6, 8'h35, 1);
        // R9: writes during emission are ignored
        wr(3'd0, 8'hEE, 0); wr(3'd6, 8'hEE, 0); wr(3'd7, 8'hEE, 0);
        wait_done();
        rd(3'd0, 8'hA0, "R9 features unchanged");
        rd(3'd6, 8'h35, "R9 command unchanged");
        rd(3'd7, 8'h00, "R9 control unchanged");

        // R10: 28-bit load, single writes only
        wr(3'd5, 8'h40, 1); wr(3'd2, 8'h07, 1); wr(3'd1, 8'h08, 1);
        wr(3'd6, 8'hC8, 1);
        wait_done();
        stall_mode = 0;
        repeat (4) @(negedge clk);
        check("R8 idle after FIS", {31'd0, fis_valid}, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule